// File: doc/BRIEF.md
# Self-Timed Sector Write Engine

This block sits on the device side of a non-volatile memory programmer. Bytes for one 128-byte sector are first staged in a holding buffer through a byte-load port. A commit strobe then names a target array (code or data) and a sector number and starts a self-timed write. The write erases the whole target sector to FFh and then stores the staged bytes. A separate strobe starts a self-timed chip erase that returns every location of both arrays to FFh. Both arrays are small register memories whose sizes are parameters. Both operation lengths are parameterised cycle counts.

Software can watch an operation finish in three ways. The active-low busy pin is low for the whole operation. Reads issued during the operation return a status byte instead of memory data. In that byte, bit 6 flips on every read. Bit 7 is the complement of bit 7 of the last byte loaded, when the read address is that byte's final location. No request is taken until a programming-enable pulse arrives while programming mode is held. A write-permission input, normally driven by a lock controller, can block sector writes, but it never blocks chip erase.

Top module: `sector_wr_engine`

## Requirements
- R1: After reset `busy_n` is 1, every location of both arrays reads FFh, and programming is locked.
- R2: Load, commit and chip-erase requests are ignored until `pgm_unlock` is pulsed while `pgm_mode` is 1. A request in the same cycle as the unlock pulse is still ignored. Dropping `pgm_mode` locks the block again.
- R3: An accepted commit drives `busy_n` low from the next cycle for exactly `WR_CYC` cycles. When requests arrive in the same cycle, chip erase wins over commit, and commit wins over load.
- R4: After a write, each target byte whose offset (bits 6:0 of the load offset) was loaded holds the last value loaded there. Every other byte of that sector reads FFh, and all other sectors are unchanged. The sector is selected by the upper address bits, so the byte address is sector*128+offset.
- R5: When `wr_allow` is 0, a commit is ignored: `busy_n` stays 1 and memory is unchanged. A chip erase is still accepted.
- R6: An accepted chip erase holds `busy_n` low for exactly `ER_CYC` cycles and then every location of both arrays reads FFh.
- R7: During a write, a read of the last byte loaded, at its final array address, returns bit 7 equal to the complement of that byte's bit 7. Any other busy read returns bit 7 as 0.
- R8: During any operation, each read returns status. Bit 6 is 1 on the first read after the start and inverts on every later read. Bits 5:0 are 0.
- R9: Loads, commits and chip erases made while busy are ignored. The staged buffer is cleared when a write finishes.
- R10: `rd_data` holds the result of a read one cycle after `rd_en`. When idle, that result is the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pgm_mode | input | 1 | Programming mode held |
| pgm_unlock | input | 1 | Programming-enable pulse |
| wr_allow | input | 1 | Sector write permitted |
| ld_en | input | 1 | Stage one byte |
| ld_off | input | 7 | Byte offset within sector |
| ld_data | input | 8 | Byte to stage |
| commit | input | 1 | Start sector write |
| cm_arr | input | 1 | Target array, 0 code, 1 data |
| cm_sect | input | ADDR_W-7 | Target sector number |
| chip_erase | input | 1 | Start chip erase |
| rd_en | input | 1 | Read request |
| rd_arr | input | 1 | Read array, 0 code, 1 data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Read result or status |
| busy_n | output | 1 | Low while an operation runs |

## Verification
A full-sector load shows that staged data lands at sector*128+offset. A three-byte partial load shows that unloaded bytes come back as FFh rather than stale data. A one-byte rewrite of an already programmed sector separates a real pre-erase from a merge with the old contents. Repeated reads of the polled address and of a different address during one write tell the bit-7 polling apart from the bit-6 toggle. Requests injected mid-operation, a commit with permission withheld, and requests before unlock or after losing programming mode each show that a rejected request leaves both memory and the buffer untouched.

// File: rtl/sector_wr_engine.sv
module sector_wr_engine #(
  parameter int SECT_BYTES = 128,
  parameter int CODE_SECT  = 2,
  parameter int DATA_SECT  = 4,
  parameter int WR_CYC     = 40,
  parameter int ER_CYC     = 30,
  parameter int ADDR_W     = $clog2((CODE_SECT > DATA_SECT ? CODE_SECT : DATA_SECT) * SECT_BYTES)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  pgm_mode,
  input  logic                                  pgm_unlock,
  input  logic                                  wr_allow,
  input  logic                                  ld_en,
  input  logic [$clog2(SECT_BYTES)-1:0]         ld_off,
  input  logic [7:0]                            ld_data,
  input  logic                                  commit,
  input  logic                                  cm_arr,
  input  logic [ADDR_W-$clog2(SECT_BYTES)-1:0]  cm_sect,
  input  logic                                  chip_erase,
  input  logic                                  rd_en,
  input  logic                                  rd_arr,
  input  logic [ADDR_W-1:0]                     rd_addr,
  output logic [7:0]                            rd_data,
  output logic                                  busy_n
);
  localparam int OFF_W      = $clog2(SECT_BYTES);
  localparam int SECT_W     = ADDR_W - OFF_W;
  localparam int CODE_BYTES = CODE_SECT * SECT_BYTES;
  localparam int DATA_BYTES = DATA_SECT * SECT_BYTES;
  localparam int CODE_AW    = $clog2(CODE_BYTES);
  localparam int DATA_AW    = $clog2(DATA_BYTES);
  localparam int CNT_W      = $clog2((WR_CYC > ER_CYC ? WR_CYC : ER_CYC) + 1);

  logic [7:0] code_mem [CODE_BYTES];
  logic [7:0] data_mem [DATA_BYTES];
  logic [7:0] stage [SECT_BYTES];
  logic [SECT_BYTES-1:0] mask;

  logic              busy, op_er, en_q, poll_ok, tgt_arr, tog;
  logic [CNT_W-1:0]  cnt;
  logic [SECT_W-1:0] tgt_sect;
  logic [OFF_W-1:0]  last_off;
  logic [7:0]        last_d;

  wire idle_ok = !busy && en_q;
  wire go_er   = idle_ok && chip_erase;
  wire go_wr   = idle_ok && !chip_erase && commit && wr_allow;
  wire take_ld = idle_ok && !chip_erase && !commit && ld_en;
  wire fin     = busy && (cnt == '0);
  wire done_wr = fin && !op_er;
  wire done_er = fin && op_er;

  wire [ADDR_W-1:0] new_base = {cm_sect, {OFF_W{1'b0}}};
  wire [ADDR_W-1:0] tgt_base = {tgt_sect, {OFF_W{1'b0}}};
  wire poll_hit = !op_er && poll_ok && (rd_arr == tgt_arr) && (rd_addr == {tgt_sect, last_off});

  assign busy_n = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (!pgm_mode) en_q <= 1'b0;
    else if (pgm_unlock) en_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; op_er <= 1'b0; cnt <= '0; poll_ok <= 1'b0;
      tgt_arr <= 1'b0; tgt_sect <= '0;
    end else if (busy) begin
      if (fin) busy <= 1'b0;
      else cnt <= cnt - 1'b1;
    end else if (go_er) begin
      busy <= 1'b1; op_er <= 1'b1; cnt <= CNT_W'(ER_CYC - 1);
    end else if (go_wr) begin
      busy <= 1'b1; op_er <= 1'b0; cnt <= CNT_W'(WR_CYC - 1);
      tgt_arr <= cm_arr; tgt_sect <= cm_sect; poll_ok <= |mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0; last_off <= '0; last_d <= '0;
    end else if (done_wr) begin
      mask <= '0;
    end else if (take_ld) begin
      mask[ld_off] <= 1'b1; last_off <= ld_off; last_d <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (take_ld) stage[ld_off] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || done_er) begin
      for (int i = 0; i < CODE_BYTES; i++) code_mem[i] <= 8'hFF;
      for (int i = 0; i < DATA_BYTES; i++) data_mem[i] <= 8'hFF;
    end else if (go_wr) begin
      for (int i = 0; i < SECT_BYTES; i++) begin
        if (cm_arr) data_mem[DATA_AW'(new_base + ADDR_W'(i))] <= 8'hFF;
        else        code_mem[CODE_AW'(new_base + ADDR_W'(i))] <= 8'hFF;
      end
    end else if (done_wr) begin
      for (int i = 0; i < SECT_BYTES; i++) begin
        if (mask[i]) begin
          if (tgt_arr) data_mem[DATA_AW'(tgt_base + ADDR_W'(i))] <= stage[i];
          else         code_mem[CODE_AW'(tgt_base + ADDR_W'(i))] <= stage[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0; tog <= 1'b0;
    end else begin
      if (go_wr || go_er) tog <= 1'b0;
      if (rd_en) begin
        if (busy) begin
          rd_data <= {poll_hit & ~last_d[7], ~tog, 6'b0};
          tog <= ~tog;
        end else begin
          rd_data <= rd_arr ? data_mem[rd_addr[DATA_AW-1:0]] : code_mem[rd_addr[CODE_AW-1:0]];
        end
      end
    end
  end

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(en_q && (chip_erase || (commit && wr_allow))));
  p_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && busy_n) |=> busy_n);
  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && !chip_erase && !wr_allow) |=> busy_n);
  p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy_n) |=> (rd_data[5:0] == 6'd0));
  p_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && cnt != '0) |=> $stable(mask));
endmodule

// File: tb/sector_wr_engine_tb.sv
module sector_wr_engine_tb_top;
  localparam int SB = 128, CS = 2, DS = 4, WRC = 40, ERC = 30, AW = 9;
  localparam int CB = CS * SB, DB = DS * SB;

  logic clk = 0, rst_n = 0;
  logic pgm_mode = 0, pgm_unlock = 0, wr_allow = 1, ld_en = 0, commit = 0, cm_arr = 0;
  logic chip_erase = 0, rd_en = 0, rd_arr = 0;
  logic [6:0] ld_off = 0;
  logic [7:0] ld_data = 0;
  logic [1:0] cm_sect = 0;
  logic [AW-1:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic busy_n;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  sector_wr_engine #(.SECT_BYTES(SB), .CODE_SECT(CS), .DATA_SECT(DS), .WR_CYC(WRC), .ER_CYC(ERC)) dut_i (
    .clk(clk), .rst_n(rst_n), .pgm_mode(pgm_mode), .pgm_unlock(pgm_unlock), .wr_allow(wr_allow),
    .ld_en(ld_en), .ld_off(ld_off), .ld_data(ld_data), .commit(commit), .cm_arr(cm_arr),
    .cm_sect(cm_sect), .chip_erase(chip_erase), .rd_en(rd_en), .rd_arr(rd_arr),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy_n(busy_n));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int mc[CB], md[DB], mb[SB];
  int m_en, m_busy, m_er, m_cnt, m_tog, m_arr, m_sect, m_last, m_lastd, m_poll;
  int exp_v, exp_rd;
  string exp_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CB; i++) mc[i] = 255;
      for (int i = 0; i < DB; i++) md[i] = 255;
      for (int i = 0; i < SB; i++) mb[i] = -1;
      m_en = 0; m_busy = 0; m_er = 0; m_cnt = 0; m_tog = 0; exp_v = 0; m_poll = 0;
    end else begin
      exp_v = rd_en;
      if (rd_en) begin
        if (m_busy != 0) begin
          int b7;
          b7 = 0;
          if (!m_er && m_poll && rd_arr == m_arr && int'(rd_addr) == m_sect * SB + m_last)
            b7 = ((m_lastd >> 7) & 1) ^ 1;
          m_tog ^= 1;
          exp_rd = b7 * 128 + m_tog * 64;
          exp_tag = (b7 != 0) ? "R7" : "R8";
        end else begin
          exp_rd = rd_arr ? md[rd_addr] : mc[rd_addr % CB];
          exp_tag = "R10";
        end
      end
      if (m_busy != 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0;
          if (m_er) begin
            for (int i = 0; i < CB; i++) mc[i] = 255;
            for (int i = 0; i < DB; i++) md[i] = 255;
          end else begin
            for (int i = 0; i < SB; i++) begin
              int v;
              v = (mb[i] >= 0) ? mb[i] : 255;
              if (m_arr != 0) md[m_sect * SB + i] = v; else mc[(m_sect * SB + i) % CB] = v;
              mb[i] = -1;
            end
          end
        end
      end else if (m_en != 0) begin
        if (chip_erase) begin
          m_busy = 1; m_er = 1; m_cnt = ERC; m_tog = 0;
        end else if (commit) begin
          if (wr_allow) begin
            m_busy = 1; m_er = 0; m_cnt = WRC; m_tog = 0;
            m_arr = cm_arr; m_sect = cm_sect; m_poll = 0;
            for (int i = 0; i < SB; i++) if (mb[i] >= 0) m_poll = 1;
          end
        end else if (ld_en) begin
          mb[ld_off] = ld_data; m_last = ld_off; m_lastd = ld_data;
        end
      end
      if (!pgm_mode) m_en = 0; else if (pgm_unlock) m_en = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(m_er ? "R6" : "R3", busy_n, (m_busy != 0) ? 0 : 1);
      if (exp_v != 0) chk(exp_tag, rd_data, exp_rd);
    end
  end

  task automatic load(input int off, input int d);
    ld_en = 1; ld_off = 7'(off); ld_data = 8'(d); @(negedge clk); ld_en = 0;
  endtask
  task automatic cmt(input int arr, input int sect);
    commit = 1; cm_arr = arr[0]; cm_sect = 2'(sect); @(negedge clk); commit = 0;
  endtask
  task automatic erase();
    chip_erase = 1; @(negedge clk); chip_erase = 0;
  endtask
  task automatic rd(input int arr, input int addr, output int val);
    rd_en = 1; rd_arr = arr[0]; rd_addr = AW'(addr); @(negedge clk); rd_en = 0; val = rd_data;
  endtask
  task automatic wait_idle(output int n);
    n = 0;
    while (!busy_n && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", busy_n, 1);
    rd(0, 5, v); chk("R1", v, 8'hFF);
    rd(1, 300, v); chk("R1", v, 8'hFF);

    pgm_mode = 1;
    load(0, 8'h12); cmt(0, 0);
    chk("R2", busy_n, 1);
    erase(); chk("R2", busy_n, 1);
    pgm_unlock = 1; commit = 1; cm_arr = 0; cm_sect = 0; @(negedge clk); pgm_unlock = 0; commit = 0;
    chk("R2", busy_n, 1);

    // full sector into data sector 1
    for (int i = 0; i < SB; i++) load(i, (i * 7 + 3) & 255);
    cmt(1, 1);
    chk("R3", busy_n, 0);
    rd(1, SB + 127, v); chk("R7", v, 8'hC0);
    rd(1, SB + 127, v); chk("R8", v, 8'h80);
    rd(1, SB + 5, v);   chk("R8", v, 8'h40);
    wait_idle(n);
    rd(1, SB + 5, v);   chk("R10", v, 38);
    rd(1, SB + 127, v); chk("R4", v, 8'h7C);

    // partial load into code sector 0
    load(0, 8'h11); load(77, 8'hA5); load(127, 8'h33);
    cmt(0, 0);
    wait_idle(n); chk("R3", n, WRC);
    rd(0, 1, v);   chk("R4", v, 8'hFF);
    rd(0, 77, v);  chk("R4", v, 8'hA5);
    rd(0, 127, v); chk("R4", v, 8'h33);

    // rewrite data sector 1 with one byte: rest must be erased
    load(10, 8'h99); cmt(1, 1); wait_idle(n);
    rd(1, SB + 10, v); chk("R4", v, 8'h99);
    rd(1, SB + 11, v); chk("R4", v, 8'hFF);

    // requests during busy are ignored
    load(0, 8'h44); cmt(1, 2);
    load(1, 8'h55); cmt(1, 3); erase();
    wait_idle(n);
    @(negedge clk); chk("R9", busy_n, 1);
    rd(1, 2 * SB, v);     chk("R9", v, 8'h44);
    rd(1, 2 * SB + 1, v); chk("R9", v, 8'hFF);
    rd(1, SB + 10, v);    chk("R9", v, 8'h99);
    cmt(1, 3); wait_idle(n);
    rd(1, 3 * SB + 1, v); chk("R9", v, 8'hFF);

    // write permission withheld
    wr_allow = 0;
    load(0, 8'h12); cmt(0, 0);
    chk("R5", busy_n, 1);
    rd(0, 0, v); chk("R5", v, 8'h11);
    erase(); chk("R5", busy_n, 0);
    wait_idle(n); chk("R6", n, ERC);
    rd(0, 77, v); chk("R6", v, 8'hFF);
    rd(1, SB + 10, v); chk("R6", v, 8'hFF);
    wr_allow = 1;

    // losing programming mode relocks
    pgm_mode = 0; @(negedge clk); pgm_mode = 1;
    cmt(0, 1); chk("R2", busy_n, 1);
    rd(0, SB, v); chk("R2", v, 8'hFF);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule